// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block is a small general-purpose I/O port with up to eight pins that a register bus reads and writes. Software sets each pin's direction, loads the value that output pins drive, and reads the current level of the pins. Each pin has its own input, output-value and output-enable signal, so the surrounding pad ring decides how the pin is physically driven.

Three registers sit at consecutive bus offsets: the pin-level register at offset 0, the output latch at offset 1 and the direction register at offset 2. A set direction bit makes the pin an input and a clear bit makes it an output, and reset makes every pin an input. The output latch keeps what was last written even while a pin is an input, so a pin that is later switched to output drives a value chosen in advance. A mode input picks how pin levels reach the read path: through a two-stage synchronizer for pins driven from another clock domain, or as a direct sample when the pins are already synchronous.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, the direction register becomes all ones over the port width and the output latch becomes zero, so after reset every pin_oe bit is 0 and reads at offsets 1 and 2 return 0x00 and the port-width mask.
- R2: Each pin_oe bit is the inverse of the matching direction bit: a direction bit of 1 makes the pin an input (pin_oe 0) and a bit of 0 makes it an output (pin_oe 1), one cycle after the direction write.
- R3: A write at offset 2 stores the low port-width bits of the write data in the direction register, and a read at offset 2 returns them.
- R4: A read at offset 1 returns the value last written at offset 1, whatever level the pins carry.
- R5: pin_out always presents the output latch; a write at offset 1 is stored while the pin is an input, and once the pin is switched to output it drives that stored value.
- R6: With in_direct at 0, a pin level applied before a clock edge is returned at offset 0 after the second rising edge, and the old level is still returned after the first edge.
- R7: With in_direct at 1, a read at offset 0 returns the present pin levels in the same cycle.
- R8: On a port narrower than eight pins, bits at and above the port width read as zero at every offset, and write data in those bits is discarded.
- R9: A read at offset 3 returns zero, and a write at offset 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_direct | input | 1 | 1: pins sampled directly; 0: pins read through the synchronizer |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 2 | Register offset: 0 pin levels, 1 output latch, 2 direction, 3 unmapped |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | PORT_W | Levels seen on the pins |
| pin_out | output | PORT_W | Value driven on pins that are outputs |
| pin_oe | output | PORT_W | Per-pin output enable, 1 drives the pin |

## Verification
The bench builds the port four pins wide, the narrowest useful case, so that the upper nibble exercises the discard and read-as-zero behaviour on every access. At that width all 256 write values at offsets 1 and 2 and all 16 pin patterns in both input modes fit in a few thousand cycles. Expected values are the write data masked to four bits, the inverted direction value, and the pin pattern delayed by two edges in synchronized mode.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    // register offsets; the order is fixed by the bus map
    typedef enum logic [ADDR_W-1:0] {
        SEL_LEVEL = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr);
    endfunction

    function automatic bus_req_t make_req(input logic we,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [DATA_W-1:0] data);
        bus_req_t r;
        r.we   = we;
        r.sel  = decode_sel(addr);
        r.data = data;
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < DEPTH; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[DEPTH-1];

    // cycles since reset, used only to gate the latency check
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    generate
        if (DEPTH == 2) begin : g_lat
            assert_sync_latency_R6: assert property (@(posedge clk) disable iff (rst)
                (warm_q >= 2'd2) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_ctl_regs.sv
`timescale 1ns/1ps
module gpio_ctl_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else if (req.we) begin
            case (req.sel)
                SEL_LATCH: latch_q <= req.data[W-1:0];
                SEL_DIR:   dir_q   <= req.data[W-1:0];
                default: ;
            endcase
        end
    end

    assert_dir_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_q == '1 && latch_q == '0));

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == SEL_DIR) |=> (dir_q == $past(req.data[W-1:0])));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(req.we && req.sel == SEL_LATCH) |=> $stable(latch_q));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_direct,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    bus_req_t          req;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] synced;
    logic [PORT_W-1:0] level;

    assign req = make_req(bus_we, bus_addr, bus_wdata);

    gpio_ctl_regs #(.W(PORT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (synced)
    );

    assign level   = in_direct ? pin_in : synced;
    assign pin_out = latch_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        bus_rdata = '0;
        case (req.sel)
            SEL_LEVEL: bus_rdata = DATA_W'(level);
            SEL_LATCH: bus_rdata = DATA_W'(latch_q);
            SEL_DIR:   bus_rdata = DATA_W'(dir_q);
            default:   bus_rdata = '0;
        endcase
    end

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=> (pin_oe == ~$past(bus_wdata[PORT_W-1:0])));

    assert_direct_read_R7: assert property (@(posedge clk) disable iff (rst)
        (in_direct && bus_addr == 2'd0) |-> (bus_rdata[PORT_W-1:0] == pin_in));

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    generate
        if (PORT_W < DATA_W) begin : g_narrow
            assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
                bus_rdata[DATA_W-1:PORT_W] == '0);
        end
    endgenerate

endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

    localparam int unsigned PW = 4;
    localparam logic [7:0]  MASK = 8'h0F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_direct = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out;
    logic [PW-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_port #(.PORT_W(PW)) u0 (
        .clk(clk), .rst(rst), .in_direct(in_direct),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, v); check("R1 dir reset", v, MASK);
        rd(2'd1, v); check("R1 latch reset", v, 8'h00);
        check("R1 oe reset", 8'(pin_oe), 8'h00);

        // R2 R3 R8: every direction value
        for (int i = 0; i < 256; i++) begin
            wr(2'd2, 8'(i));
            rd(2'd2, v); check("R3 R8 dir readback", v, 8'(i) & MASK);
            check("R2 oe inverse", 8'(pin_oe), ~8'(i) & MASK);
        end

        // R4 R5 R8: every latch value, pins held at the complement
        wr(2'd2, 8'h00);
        for (int i = 0; i < 256; i++) begin
            pin_in = ~PW'(i);
            wr(2'd1, 8'(i));
            rd(2'd1, v); check("R4 R8 latch readback", v, 8'(i) & MASK);
            check("R5 pin_out", 8'(pin_out), 8'(i) & MASK);
        end

        // R5 stored while input, driven after switch
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h0A);
        check("R5 oe while input", 8'(pin_oe), 8'h00);
        check("R5 latch while input", 8'(pin_out), 8'h0A);
        wr(2'd2, 8'h0C);
        check("R5 oe after switch", 8'(pin_oe), 8'h03);
        check("R5 value after switch", 8'(pin_out), 8'h0A);

        // R7 direct sampling
        in_direct = 1'b1;
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            pin_in = PW'(p);
            rd(2'd0, v); check("R7 direct level", v, 8'(p));
        end

        // R6 synchronized sampling, two-edge latency
        in_direct = 1'b0;
        pin_in = '0;
        repeat (3) @(negedge clk);
        for (int p = 1; p < 17; p++) begin
            logic [7:0] prev;
            prev = 8'((p - 1) % 16);
            @(negedge clk);
            pin_in = PW'(p % 16);
            rd(2'd0, v); check("R6 same cycle", v, prev);
            @(negedge clk);
            rd(2'd0, v); check("R6 after one edge", v, prev);
            @(negedge clk);
            rd(2'd0, v); check("R6 after two edges", v, 8'(p % 16));
        end

        // R9 unmapped offset
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h09);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R9 unmapped read", v, 8'h00);
        rd(2'd1, v); check("R9 latch untouched", v, 8'h05);
        rd(2'd2, v); check("R9 dir untouched", v, 8'h09);
        check("R9 oe untouched", 8'(pin_oe), 8'h06);

        // R1 reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(2'd2, v); check("R1 dir re-reset", v, MASK);
        rd(2'd1, v); check("R1 latch re-reset", v, 8'h00);
        check("R1 oe re-reset", 8'(pin_oe), 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule